// File: doc/BRIEF.md
# Watchdog and Interrupt Flag Controller

This block pairs a software-serviced watchdog with a small event-flag register that merges three interrupt sources onto one interrupt line. A processor programs a 6-bit time-out and must strobe the watchdog before that many timebase ticks have passed. If it does not, a watchdog event is raised. The timebase is an internal prescaler that divides the block clock.

Two further events enter as single-cycle pulses from neighbouring logic: a calendar alarm match and a supply-failure warning. Each of the three sources always latches its own flag. A separate enable bit decides whether that flag also drives the interrupt output. One read of the flag register returns all flags and clears them, masked or not.

A lock bit travels with every watchdog write. With the lock set, the stored time-out is left untouched, so a routine service strobe cannot corrupt it.

Top module: `wdog_irq_ctrl`

## Requirements
- R1: After reset the flags read 3'b000, the interrupt output is 0, the stored time-out reads 0 and all enables are 0.
- R2: A watchdog write (wd_wdata bits 5:0 time-out, bit 6 lock, bit 7 strobe) stores bits 5:0 as the time-out only when bit 6 is 0. With bit 6 at 1, the stored time-out keeps its value.
- R3: A watchdog write with bit 7 set reloads the countdown and restarts the prescaler. The reload value is the newly written time-out when unlocked, and the stored time-out when locked. A new strobe before expiry restarts the full interval.
- R4: With a time-out T from 1 to 63, the watchdog flag (bit 0) becomes 1 exactly T*TICK_DIV clock cycles after the strobing write edge, and not one cycle earlier.
- R5: A strobe with a time-out of 0 never produces a watchdog event.
- R6: After expiry the countdown stays idle, and the watchdog flag is not set again until a new strobe.
- R7: An alarm pulse sets flag bit 1 and a supply-fail pulse sets flag bit 2, whether or not their enables are set.
- R8: The interrupt output is 1 exactly when some flag is 1 and its enable bit (same bit position) is 1. A flag that is masked does not drive it.
- R9: flag_rdata always shows the flags. A cycle with flag_rd high clears all flags at that clock edge, masked ones included.
- R10: An event that arrives in the same cycle as a read leaves its flag set after the read.
- R11: Writing the enables changes the interrupt output from the next cycle and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_wr | input | 1 | Watchdog control write strobe |
| wd_wdata | input | 8 | Bits 5:0 time-out, bit 6 lock, bit 7 service strobe |
| ie_wr | input | 1 | Interrupt enable write strobe |
| ie_wdata | input | 3 | Enables: bit 0 watchdog, bit 1 alarm, bit 2 supply fail |
| flag_rd | input | 1 | Flag read; clears the flags at the clock edge |
| alarm_evt | input | 1 | Single-cycle alarm match pulse |
| pfail_evt | input | 1 | Single-cycle supply-fail pulse |
| flag_rdata | output | 3 | Current flags, same bit order as the enables |
| tmo_value | output | 6 | Stored watchdog time-out |
| irq | output | 1 | Shared interrupt output |

## Verification
The hardest situations to reach are a strobe that lands just before expiry and a read that coincides with a new event. The bench gets to the first by strobing partway through an interval with the lock set. It then counts the full interval afresh from the new edge and checks the cycle before and the cycle of the expected flag. For the second, it drives an alarm pulse in the very cycle that flag_rd is high. It also checks the one-tick time-out and the zero time-out.

// File: rtl/wdi_pkg.sv
package wdi_pkg;
  localparam int TMO_W  = 6;
  localparam int NSRC   = 3;
  localparam int SRC_WD  = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PF  = 2;

  // Watchdog control word: strobe in the top bit, lock below it, time-out low
  typedef struct packed {
    logic             strobe;
    logic             lock;
    logic [TMO_W-1:0] tmo;
  } wd_ctl_t;

  function automatic logic [NSRC-1:0] next_flags(input logic [NSRC-1:0] cur,
                                                 input logic [NSRC-1:0] evt,
                                                 input logic            clr);
    return (cur & {NSRC{~clr}}) | evt;
  endfunction

  function automatic logic irq_of(input logic [NSRC-1:0] flags,
                                  input logic [NSRC-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/wdi_prescale.sv
module wdi_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (restart || tick) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R4
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdi_counter.sv
module wdi_counter #(
  parameter int W = wdi_pkg::TMO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reload,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  assign expire = tick && !reload && (cnt_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (reload)                 cnt_q <= load_val;
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // R3
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(load_val));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload) |=> cnt_q == '0);
  // R4
  expire_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == '0);
endmodule

// File: rtl/wdi_flags.sv
module wdi_flags
  import wdi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            rd,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  logic [NSRC-1:0] flags_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= next_flags(flags_q, evt, rd);
      if (en_wr) en_q <= en_wdata;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_of(flags_q, en_q);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && evt == '0) |=> flags_q == '0);
  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (flags_q & $past(evt)) == $past(evt));
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (flags_q & $past(flags_q)) == $past(flags_q));
endmodule

// File: rtl/wdog_irq_ctrl.sv
module wdog_irq_ctrl
  import wdi_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_wr,
  input  logic [7:0]       wd_wdata,
  input  logic             ie_wr,
  input  logic [2:0]       ie_wdata,
  input  logic             flag_rd,
  input  logic             alarm_evt,
  input  logic             pfail_evt,
  output logic [2:0]       flag_rdata,
  output logic [5:0]       tmo_value,
  output logic             irq
);
  wd_ctl_t          ctl;
  logic [TMO_W-1:0] tmo_q;
  logic [TMO_W-1:0] load_val;
  logic             reload, tick, wd_expire;
  logic [NSRC-1:0]  evt;

  assign ctl      = wd_ctl_t'(wd_wdata);
  assign reload   = wd_wr && ctl.strobe;
  assign load_val = ctl.lock ? tmo_q : ctl.tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tmo_q <= '0;
    else if (wd_wr && !ctl.lock) tmo_q <= ctl.tmo;
  end

  assign tmo_value = tmo_q;

  wdi_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(reload), .tick(tick)
  );

  wdi_counter #(.W(TMO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
    .load_val(load_val), .expire(wd_expire)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_WD]  = wd_expire;
    evt[SRC_ALM] = alarm_evt;
    evt[SRC_PF]  = pfail_evt;
  end

  wdi_flags u_flg (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd(flag_rd),
    .en_wr(ie_wr), .en_wdata(ie_wdata), .flags(flag_rdata), .irq(irq)
  );

  // R2
  locked_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_wr && ctl.lock) |=> $stable(tmo_q));
  // R4
  expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> flag_rdata[SRC_WD]);
endmodule

// File: tb/wdog_irq_ctrl_tb.sv
`timescale 1ns/100ps
module wdog_irq_ctrl_tb;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0;
  logic wd_wr = 0, ie_wr = 0, flag_rd = 0, alarm_evt = 0, pfail_evt = 0;
  logic [7:0] wd_wdata = '0;
  logic [2:0] ie_wdata = '0;
  logic [2:0] flag_rdata;
  logic [5:0] tmo_value;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;

  int    q_sig[$];
  int    q_exp[$];
  string q_req[$];

  always #2.5 clk = ~clk;

  wdog_irq_ctrl #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wd_wr(wd_wr), .wd_wdata(wd_wdata),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata), .flag_rd(flag_rd),
    .alarm_evt(alarm_evt), .pfail_evt(pfail_evt),
    .flag_rdata(flag_rdata), .tmo_value(tmo_value), .irq(irq)
  );

  // Monitor: pops expected items and compares them with the ports
  always @(negedge clk) begin
    #0.5;
    while (q_sig.size() > 0) begin
      int s, e, a;
      string r;
      s = q_sig.pop_front();
      e = q_exp.pop_front();
      r = q_req.pop_front();
      case (s)
        0:       a = int'(flag_rdata);
        1:       a = int'(irq);
        default: a = int'(tmo_value);
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s sig=%0d actual=%0d expected=%0d", r, s, a, e);
      end
    end
  end

  task automatic push(int sig, int exp, string req);
    q_sig.push_back(sig);
    q_exp.push_back(exp);
    q_req.push_back(req);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wd_write(logic [7:0] d);
    wd_wr = 1; wd_wdata = d;
    step(1);
    wd_wr = 0;
  endtask

  task automatic ie_write(logic [2:0] d);
    ie_wr = 1; ie_wdata = d;
    step(1);
    ie_wr = 0;
  endtask

  task automatic read_clear();
    flag_rd = 1;
    step(1);
    flag_rd = 0;
  endtask

  task automatic pulse_alarm();
    alarm_evt = 1; step(1); alarm_evt = 0;
  endtask

  task automatic pulse_pfail();
    pfail_evt = 1; step(1); pfail_evt = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    push(0, 0, "R1 flags"); push(1, 0, "R1 irq"); push(2, 0, "R1 tmo");

    // R5: strobe with a zero time-out
    wd_write(8'h80);
    step(200);
    push(0, 0, "R5 zero time-out");

    // R2: unlocked write stores, locked write keeps
    wd_write(8'h05);
    push(2, 5, "R2 unlocked store");
    wd_write(8'h49);
    push(2, 5, "R2 locked keep");

    // R3/R4: locked strobe reloads with stored 5
    wd_write(8'hFF);
    push(2, 5, "R2 locked strobe keep");
    step(5 * DIV - 1);
    push(0, 0, "R4 one cycle before expiry");
    step(1);
    push(0, 1, "R4 expiry cycle");
    push(1, 0, "R8 masked watchdog");

    // R6/R9
    step(100);
    push(0, 1, "R6 flag held");
    read_clear();
    push(0, 0, "R9 read clears masked flag");
    step(100);
    push(0, 0, "R6 no re-fire");

    // R4 boundary T=1
    wd_write(8'h81);
    step(DIV - 1);
    push(0, 0, "R4 T=1 before");
    step(1);
    push(0, 1, "R4 T=1 expiry");
    read_clear();

    // R3 restrobe mid-interval, R8 enabled watchdog
    ie_write(3'b001);
    push(1, 0, "R11 enable without flag");
    wd_write(8'h85);
    step(15);
    wd_write(8'hC0);
    step(5 * DIV - 1);
    push(0, 0, "R3 restrobe restarts interval");
    step(1);
    push(0, 1, "R3 expiry after restrobe");
    push(1, 1, "R8 enabled watchdog irq");

    // R7 sources set flags regardless of enable
    pulse_alarm();
    push(0, 3, "R7 alarm flag");
    ie_write(3'b000);
    push(1, 0, "R11 disable drops irq");
    push(0, 3, "R11 flags unchanged");
    pulse_pfail();
    push(0, 7, "R7 pfail flag");
    push(1, 0, "R8 all masked");

    // R10 event during read
    flag_rd = 1; alarm_evt = 1;
    push(0, 7, "R9 readback");
    step(1);
    flag_rd = 0; alarm_evt = 0;
    push(0, 2, "R10 event survives read");

    ie_write(3'b010);
    push(1, 1, "R11 enable raises irq");
    read_clear();
    push(0, 0, "R9 cleared");
    push(1, 0, "R8 no flag no irq");

    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule